// File: doc/BRIEF.md
# Zero-Suppressing Hit Finder and Output Multiplexer

This block sits behind the per-channel digitisers of one sensor row. Each channel delivers two signed samples: one taken before the charge is cleared and one taken after. For every channel the block subtracts the two samples to remove the pedestal, which is correlated double sampling. It then compares the difference with a programmable threshold and records the result in a per-row hit mask. Only channels that pass the threshold leave the block. They go out one at a time on a single shared output stream toward a converter or readout link, and each word is tagged with its channel index.

Captured rows go into a two-row buffer, so a new row can be accepted while the previous one is still being drained. A drain state machine walks the hit mask of the oldest row. It uses a lowest-index-first priority encoder and clears each bit as its word is accepted. After the last hit it emits an end-of-row marker and then releases the row.

The drain machine has three states:
- `ST_IDLE` waits for a buffered row. When one is present it loads that row's hit mask and moves to `ST_HITS` if any bit is set, or straight to `ST_MARK` if none is.
- `ST_HITS` presents the lowest pending hit. On each accepted word it clears that bit. When the last bit is cleared it moves to `ST_MARK`.
- `ST_MARK` presents the end-of-row marker. When the marker is accepted it frees the row and returns to `ST_IDLE`.

Top module: `zs_hit_mux`

## Requirements
- R1: For each channel the output value is the 13-bit signed difference `pre - post` of that channel's two 12-bit signed samples, and it is exact over the full input range (for example, 2047 - (-2048) = 4095).
- R2: A channel is a hit exactly when its difference is strictly greater than the 12-bit signed threshold `thresh`, as sampled in the cycle the row is accepted. A difference equal to the threshold is not a hit.
- R3: Channels that are not hits never appear on the output.
- R4: The hits of a row leave in strictly ascending channel order. While `out_ready` stays high, consecutive hits of a row are accepted on consecutive clocks.
- R5: Every hit word carries its channel number on `out_chan`, with `out_eor` = 0.
- R6: After the last hit of a row, one end-of-row word follows, encoded as `out_eor` = 1, `out_chan` = 0 and `out_value` = 0. A row with no hits produces only this word.
- R7: The buffer holds two rows. While it is full, `row_ready` is low, and no accepted row is lost or reordered.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_eor`, `out_chan` and `out_value` hold their values.
- R9: After reset, `out_valid` is 0 and `row_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh | input | 12 | Signed hit threshold, used when a row is accepted |
| row_valid | input | 1 | A row of samples is offered |
| row_ready | output | 1 | Buffer can accept a row |
| row_pre | input | 1536 | Pre-clear samples, channel c at bits [12c+11:12c] |
| row_post | input | 1536 | Post-clear samples, same packing |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer accepts the word |
| out_eor | output | 1 | Word is the end-of-row marker |
| out_chan | output | 7 | Channel number of a hit |
| out_value | output | 13 | Signed pedestal-corrected value of a hit |

## Verification
The assertions check, on every cycle, the properties that depend only on the current cycle and the one before it:
- the output holds steady while it is stalled;
- channel numbers rise within a row;
- the state machine returns to idle after each marker;
- the buffer never holds more than two rows and never frees a row it does not hold.

Several behaviours cannot be seen in a single cycle and are shown only by the bench's scenarios, each scored against differences computed independently: correct arithmetic at the sample extremes, the strict threshold boundary, whether the selected channel set is complete, marker placement for empty rows and full rows, and lossless back-pressure with both buffer entries occupied.

// File: rtl/zs_hit_pkg.sv
package zs_hit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HITS = 2'd1,
        ST_MARK = 2'd2
    } drain_state_t;

    localparam int DIFF_GUARD = 1;

endpackage

// File: rtl/zs_cds_compare.sv
module zs_cds_compare #(
    parameter int NCH = 128,
    parameter int SW  = 12,
    localparam int DW = SW + zs_hit_pkg::DIFF_GUARD
) (
    input  logic [NCH*SW-1:0] pre_flat,
    input  logic [NCH*SW-1:0] post_flat,
    input  logic [SW-1:0]     thresh,
    output logic [NCH*DW-1:0] diff_flat,
    output logic [NCH-1:0]    hit_mask
);

    logic signed [DW-1:0] thr_ext;
    assign thr_ext = $signed({thresh[SW-1], thresh});

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic signed [DW-1:0] a_ext;
        logic signed [DW-1:0] b_ext;
        logic signed [DW-1:0] d;
        assign a_ext = $signed({pre_flat[c*SW+SW-1], pre_flat[c*SW +: SW]});
        assign b_ext = $signed({post_flat[c*SW+SW-1], post_flat[c*SW +: SW]});
        assign d     = a_ext - b_ext;
        assign diff_flat[c*DW +: DW] = d;
        assign hit_mask[c] = (d > thr_ext);
    end

endmodule

// File: rtl/zs_row_buffer.sv
module zs_row_buffer #(
    parameter int NCH   = 128,
    parameter int DW    = 13,
    parameter int DEPTH = 2,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [NCH-1:0]    push_mask,
    input  logic [NCH*DW-1:0] push_diff,
    input  logic              pop,
    output logic              full,
    output logic              head_valid,
    output logic [NCH-1:0]    head_mask,
    output logic [NCH*DW-1:0] head_diff
);

    logic [NCH-1:0]    mask_mem [DEPTH];
    logic [NCH*DW-1:0] diff_mem [DEPTH];
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;
    logic [CW-1:0]     count;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mask_mem[wr_ptr] <= push_mask;
                diff_mem[wr_ptr] <= push_diff;
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            if (push && !pop) begin
                count <= count + CW'(1);
            end else if (pop && !push) begin
                count <= count - CW'(1);
            end
        end
    end

    assign full       = (int'(count) == DEPTH);
    assign head_valid = (count != '0);
    assign head_mask  = mask_mem[rd_ptr];
    assign head_diff  = diff_mem[rd_ptr];

    a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

endmodule

// File: rtl/zs_drain_fsm.sv
module zs_drain_fsm #(
    parameter int NCH  = 128,
    parameter int DW   = 13,
    localparam int IW  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid,
    input  logic [NCH-1:0]    head_mask,
    input  logic [NCH*DW-1:0] head_diff,
    output logic              pop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_eor,
    output logic [IW-1:0]     out_chan,
    output logic [DW-1:0]     out_value
);

    import zs_hit_pkg::*;

    drain_state_t state_q, state_d;
    logic [NCH-1:0] pend_q, pend_d;
    logic [IW-1:0]  pick;
    logic [NCH-1:0] pick_onehot;

    // lowest pending channel wins
    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend_q[i]) pick = IW'(i);
        end
        pick_onehot = '0;
        pick_onehot[pick] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        pend_d    = pend_q;
        pop       = 1'b0;
        out_valid = 1'b0;
        out_eor   = 1'b0;
        out_chan  = '0;
        out_value = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (head_valid) begin
                    pend_d  = head_mask;
                    state_d = (head_mask != '0) ? ST_HITS : ST_MARK;
                end
            end
            ST_HITS: begin
                out_valid = 1'b1;
                out_chan  = pick;
                out_value = head_diff[int'(pick)*DW +: DW];
                if (out_ready) begin
                    pend_d = pend_q & ~pick_onehot;
                    if ((pend_q & ~pick_onehot) == '0) state_d = ST_MARK;
                end
            end
            ST_MARK: begin
                out_valid = 1'b1;
                out_eor   = 1'b1;
                if (out_ready) begin
                    pop     = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_eor)
            && $stable(out_chan) && $stable(out_value)));

    a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_eor) |=>
            (!out_valid || out_eor || (out_chan > $past(out_chan))));

    a_r6_marker_ends_row: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eor) |=> !out_valid);

endmodule

// File: rtl/zs_hit_mux.sv
module zs_hit_mux #(
    parameter int NCH   = 128,
    parameter int SW    = 12,
    parameter int DEPTH = 2,
    localparam int DW   = SW + 1,
    localparam int IW   = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW-1:0]     thresh,
    input  logic              row_valid,
    output logic              row_ready,
    input  logic [NCH*SW-1:0] row_pre,
    input  logic [NCH*SW-1:0] row_post,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_eor,
    output logic [IW-1:0]     out_chan,
    output logic [DW-1:0]     out_value
);

    logic [NCH*DW-1:0] cap_diff;
    logic [NCH-1:0]    cap_mask;
    logic              buf_full;
    logic              buf_push;
    logic              buf_pop;
    logic              head_valid;
    logic [NCH-1:0]    head_mask;
    logic [NCH*DW-1:0] head_diff;

    zs_cds_compare #(.NCH(NCH), .SW(SW)) u_cds (
        .pre_flat  (row_pre),
        .post_flat (row_post),
        .thresh    (thresh),
        .diff_flat (cap_diff),
        .hit_mask  (cap_mask)
    );

    assign row_ready = !buf_full;
    assign buf_push  = row_valid && row_ready;

    zs_row_buffer #(.NCH(NCH), .DW(DW), .DEPTH(DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (buf_push),
        .push_mask  (cap_mask),
        .push_diff  (cap_diff),
        .pop        (buf_pop),
        .full       (buf_full),
        .head_valid (head_valid),
        .head_mask  (head_mask),
        .head_diff  (head_diff)
    );

    zs_drain_fsm #(.NCH(NCH), .DW(DW)) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (head_valid),
        .head_mask  (head_mask),
        .head_diff  (head_diff),
        .pop        (buf_pop),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_eor    (out_eor),
        .out_chan   (out_chan),
        .out_value  (out_value)
    );

    a_r9_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!head_valid) |-> !out_valid);

endmodule

// File: tb/tb_zs_hit_mux.sv
module tb_zs_hit_mux;

    localparam int NCH = 128;
    localparam int SW  = 12;
    localparam int DW  = 13;
    localparam int IW  = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [SW-1:0] thresh = '0;
    logic row_valid = 1'b0;
    logic row_ready;
    logic [NCH*SW-1:0] row_pre;
    logic [NCH*SW-1:0] row_post;
    logic out_valid;
    logic out_ready = 1'b0;
    logic out_eor;
    logic [IW-1:0] out_chan;
    logic [DW-1:0] out_value;

    logic signed [SW-1:0] pre_a  [NCH];
    logic signed [SW-1:0] post_a [NCH];

    always #5 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            row_pre[c*SW +: SW]  = pre_a[c];
            row_post[c*SW +: SW] = post_a[c];
        end
    end

    zs_hit_mux dut (
        .clk(clk), .rst_n(rst_n), .thresh(thresh),
        .row_valid(row_valid), .row_ready(row_ready),
        .row_pre(row_pre), .row_post(row_post),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_eor(out_eor), .out_chan(out_chan), .out_value(out_value)
    );

    // expected word: {eor, chan, value}
    logic [DW+IW:0] exp_q [$];
    int n_checks = 0;
    int n_fails  = 0;
    int rdy_mode = 0;   // 0 always ready, 1 random, 2 stalled
    int cyc = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_row();
        for (int c = 0; c < NCH; c++) begin
            pre_a[c] = '0;
            post_a[c] = '0;
        end
    endtask

    // driver: scores the row, then offers it
    task automatic send_row();
        logic signed [DW-1:0] d;
        logic signed [DW-1:0] t;
        t = $signed({thresh[SW-1], thresh});
        for (int c = 0; c < NCH; c++) begin
            d = DW'(pre_a[c]) - DW'(post_a[c]);
            d = $signed({pre_a[c][SW-1], pre_a[c]}) - $signed({post_a[c][SW-1], post_a[c]});
            if (d > t) exp_q.push_back({1'b0, IW'(c), d});
        end
        exp_q.push_back({1'b1, {IW{1'b0}}, {DW{1'b0}}});
        @(posedge clk) #1;
        row_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (row_ready) break;
        end
        @(posedge clk) #1;
        row_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        unique case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = ($urandom_range(0, 3) != 0);
            default: out_ready = 1'b0;
        endcase
    end

    // monitor
    int last_hit_cyc = -10;
    initial begin
        logic [DW+IW:0] e;
        forever begin
            @(negedge clk);
            if (rst_n && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected word chan", out_chan, -1);
                end else begin
                    e = exp_q.pop_front();
                    check(out_eor == e[DW+IW], "R6", "eor flag", out_eor, e[DW+IW]);
                    check(out_chan == e[DW +: IW], "R4/R5", "channel", out_chan, e[DW +: IW]);
                    check(out_value == e[DW-1:0], "R1/R2", "value",
                          $signed(out_value), $signed(e[DW-1:0]));
                    if (!out_eor && rdy_mode == 0 && last_hit_cyc == cyc - 1)
                        check(1'b1, "R4", "back-to-back", 1, 1);
                    if (!out_eor && rdy_mode == 0 && !e[DW+IW] && exp_q.size() > 0
                        && !exp_q[0][DW+IW])
                        last_hit_cyc = cyc;
                    else
                        last_hit_cyc = -10;
                end
            end else if (rst_n && rdy_mode == 0 && last_hit_cyc == cyc - 1) begin
                check(1'b0, "R4", "gap between hits at cycle", cyc, last_hit_cyc + 1);
                last_hit_cyc = -10;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic drain_wait();
        int n = 0;
        while ((exp_q.size() != 0 || out_valid) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(exp_q.size() == 0, "R7", "items left after drain", exp_q.size(), 0);
    endtask

    initial begin
        clear_row();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
        check(row_ready == 1'b1, "R9", "row_ready after reset", row_ready, 1);

        // R2 boundary, R1 extremes, R3 suppression
        thresh = 12'sd100;
        clear_row();
        pre_a[0] = 12'sd150;  post_a[0] = 12'sd20;    // 130 hit
        pre_a[5] = 12'sd2047; post_a[5] = -12'sd2048; // 4095 hit (R1)
        pre_a[7] = 12'sd100;  post_a[7] = 12'sd0;     // equal: not hit (R2)
        pre_a[9] = 12'sd101;  post_a[9] = 12'sd0;     // 101 hit
        pre_a[20] = -12'sd2048; post_a[20] = 12'sd2047; // -4095 no hit
        pre_a[127] = 12'sd300; post_a[127] = 12'sd50; // hit, last channel
        send_row();
        drain_wait();

        // R6 empty row: marker only
        clear_row();
        send_row();
        drain_wait();

        // R4 all channels hit, consecutive under continuous ready
        thresh = -12'sd5;
        for (int c = 0; c < NCH; c++) begin
            pre_a[c] = 12'(c);
            post_a[c] = 12'(c % 3);
        end
        send_row();
        drain_wait();

        // R7/R8 back-pressure with both entries held
        rdy_mode = 2;
        thresh = 12'sd10;
        clear_row();
        pre_a[3] = 12'sd40; pre_a[60] = 12'sd77;
        send_row();
        clear_row();
        pre_a[1] = 12'sd11; pre_a[2] = 12'sd10;
        send_row();
        @(negedge clk);
        check(row_ready == 1'b0, "R7", "row_ready with two rows held", row_ready, 1'b0);
        clear_row();
        pre_a[126] = 12'sd500;
        fork
            send_row();
        join_none
        repeat (20) @(negedge clk);
        check(row_ready == 1'b0, "R7", "row_ready still low", row_ready, 1'b0);
        check(out_valid && out_chan == 7'd3, "R8", "stalled head channel", out_chan, 3);
        check(out_value == 13'sd40, "R8", "stalled head value", $signed(out_value), 40);
        rdy_mode = 0;
        wait fork;
        drain_wait();

        // random rows with random consumer stalls
        rdy_mode = 1;
        for (int r = 0; r < 12; r++) begin
            thresh = 12'($urandom_range(0, 600));
            for (int c = 0; c < NCH; c++) begin
                pre_a[c]  = 12'($urandom);
                post_a[c] = 12'($urandom_range(0, 400));
            end
            send_row();
        end
        rdy_mode = 0;
        drain_wait();

        finish_run();
    end

endmodule